// File: doc/BRIEF.md
# Graphic LCD Host Bus Interface

This block is the processor-facing side of a 64-column graphic display driver. It decodes a 6800-style strobe bus into one of four accesses. An enable strobe qualifies each access. A read/write line and a register-select line pick the kind of access, and three chip selects must all be asserted. The four accesses are an instruction write, a status read, a display-RAM write and a display-RAM read. The block owns a 512-byte display memory arranged as 8 pages of 64 columns. It also holds the page register, the auto-incrementing column counter, the display enable flag, the start-line register and the busy flag.

The bus inputs are brought into the internal clock domain through a synchroniser chain. A falling edge of the synchronised strobe launches the state machine. The machine has three states. ST_IDLE waits for an accepted strobe fall; the transition idle-to-exec is taken when the strobe falls while selected, out of reset and idle, and the access is not a status read. ST_EXEC performs the captured access in one cycle. The transition exec-to-hold is taken when the busy length exceeds one cycle, and exec-to-idle otherwise. ST_HOLD pads the busy window; the transition hold-to-idle is taken when the pad count is used up. Busy is reported whenever the machine is not in ST_IDLE.

Data reads are pipelined through an output register. Each read returns what the register already holds, then reloads it from the current address. The scan engine can read the display enable flag and the start line from the outputs.

Top module: `glcd_host_if`

## Requirements
- R1: An access takes effect only while cs1_n is 0, cs2_n is 0 and cs3 is 1. Otherwise no register or memory changes, and db_oe stays 0.
- R2: With bus_rw = 0 the bus value is taken at the falling edge of bus_e. With bus_rw = 1 and the chip selected, db_oe is 1 while bus_e is high, after synchronisation.
- R3: With bus_rs = 0 and bus_rw = 0, the byte 0011111d sets disp_on to d. The byte 11 followed by a 6-bit value n loads start_line with n.
- R4: A status read (bus_rs = 0, bus_rw = 1) returns bit 7 = busy, bit 5 = 1 when the display is off, bit 4 = 1 while rst_n is low, and 0 in all other bits. It changes no state.
- R5: The byte 01 followed by a 6-bit column sets the column. The byte 10111 followed by a 3-bit page sets the page. A data write (bus_rs = 1, bus_rw = 0) stores the byte at memory address {page, column}.
- R6: A data read (bus_rs = 1, bus_rw = 1) returns the output register. It then reloads that register from {page, column}, so the first read after setting an address returns stale content.
- R7: The column advances by one after each data read or write and wraps from 63 to 0. The page never advances by itself.
- R8: After each accepted access, busy (status bit 7) is 1 for BUSY_CYC internal clocks (1 to 3, default 2). Any strobe fall that arrives while busy is ignored.
- R9: While rst_n is 0, disp_on is 0, start_line is 0 and only status reads answer. After release the display stays off until it is switched on by an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_e | input | 1 | Bus enable strobe |
| bus_rw | input | 1 | 1 = read, 0 = write |
| bus_rs | input | 1 | 1 = display data, 0 = instruction/status |
| cs1_n | input | 1 | Chip select, active low |
| cs2_n | input | 1 | Chip select, active low |
| cs3 | input | 1 | Chip select, active high |
| db_in | input | 8 | Data from the host |
| db_out | output | 8 | Data to the host |
| db_oe | output | 1 | Host data output enable |
| disp_on | output | 1 | Display enable flag |
| start_line | output | 6 | Top display line |

## Verification
The bus passes through two synchroniser stages, so db_oe and read data appear two clock edges after the strobe rises. The bench holds bus_e high for four cycles and samples on the last falling clock edge before it drops the strobe. A strobe fall is seen two edges later, and the access executes on the third. Register effects therefore land four edges after the fall, and the bench waits eight cycles before it inspects the outputs. For busy, a status read is raised one cycle after a write strobe falls, and it is sampled three edges later, inside the ST_EXEC cycle. A strobe that falls four edges after a previous accepted fall lands in ST_HOLD, and the bench checks that it is dropped.

// File: rtl/glcd_pkg.sv
package glcd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_HOLD = 2'd2
    } host_state_t;

    typedef struct packed {
        logic       rs;
        logic       rw;
        logic [7:0] db;
    } bus_cmd_t;

    localparam int STAT_BUSY_BIT  = 7;
    localparam int STAT_OFF_BIT   = 5;
    localparam int STAT_RESET_BIT = 4;

    function automatic logic op_is_display(input logic [7:0] b);
        return b[7:1] == 7'b0011111;
    endfunction

    function automatic logic op_is_column(input logic [7:0] b);
        return b[7:6] == 2'b01;
    endfunction

    function automatic logic op_is_page(input logic [7:0] b);
        return b[7:3] == 5'b10111;
    endfunction

    function automatic logic op_is_start(input logic [7:0] b);
        return b[7:6] == 2'b11;
    endfunction

endpackage

// File: rtl/glcd_bus_sync.sv
module glcd_bus_sync #(
    parameter int STAGES = 2,
    parameter int DW     = 8
) (
    input  logic          clk,
    input  logic          e_raw,
    input  logic          rw_raw,
    input  logic          rs_raw,
    input  logic          sel_raw,
    input  logic [DW-1:0] db_raw,
    output logic          e_hi,
    output logic          e_fall,
    output logic          rw_s,
    output logic          rs_s,
    output logic          sel_s,
    output logic [DW-1:0] db_s
);
    localparam int W = DW + 4;

    logic [W-1:0] stage [STAGES];
    logic         e_last;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    stage[0] <= {e_raw, rw_raw, rs_raw, sel_raw, db_raw};
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    stage[g] <= stage[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        e_last <= stage[STAGES-1][W-1];
    end

    assign e_hi   = stage[STAGES-1][W-1];
    assign rw_s   = stage[STAGES-1][W-2];
    assign rs_s   = stage[STAGES-1][W-3];
    assign sel_s  = stage[STAGES-1][W-4];
    assign db_s   = stage[STAGES-1][DW-1:0];
    assign e_fall = e_last & ~e_hi;

endmodule

// File: rtl/glcd_ram.sv
module glcd_ram #(
    parameter int AW = 9,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/glcd_host_if.sv
module glcd_host_if
    import glcd_pkg::*;
#(
    parameter int COLS        = 64,
    parameter int PAGES       = 8,
    parameter int BUSY_CYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_e,
    input  logic       bus_rw,
    input  logic       bus_rs,
    input  logic       cs1_n,
    input  logic       cs2_n,
    input  logic       cs3,
    input  logic [7:0] db_in,
    output logic [7:0] db_out,
    output logic       db_oe,
    output logic       disp_on,
    output logic [5:0] start_line
);
    localparam int COL_W  = $clog2(COLS);
    localparam int PAGE_W = $clog2(PAGES);
    localparam int ADDR_W = PAGE_W + COL_W;
    localparam int PAD    = (BUSY_CYC > 1) ? BUSY_CYC - 2 : 0;

    logic             e_hi, e_fall, rw_s, rs_s, sel_s;
    logic [7:0]       db_s;
    host_state_t      state, state_nx;
    bus_cmd_t         cmd;
    logic [1:0]       hold_cnt;
    logic [COL_W-1:0] col;
    logic [PAGE_W-1:0] page;
    logic [7:0]       out_reg;
    logic [7:0]       ram_rdata;
    logic             ram_we;
    logic             accept;
    logic             busy;

    glcd_bus_sync #(.STAGES(SYNC_STAGES), .DW(8)) u_sync (
        .clk     (clk),
        .e_raw   (bus_e),
        .rw_raw  (bus_rw),
        .rs_raw  (bus_rs),
        .sel_raw (~cs1_n & ~cs2_n & cs3),
        .db_raw  (db_in),
        .e_hi    (e_hi),
        .e_fall  (e_fall),
        .rw_s    (rw_s),
        .rs_s    (rs_s),
        .sel_s   (sel_s),
        .db_s    (db_s)
    );

    glcd_ram #(.AW(ADDR_W), .DW(8)) u_ram (
        .clk   (clk),
        .we    (ram_we),
        .addr  ({page, col}),
        .wdata (cmd.db),
        .rdata (ram_rdata)
    );

    assign busy   = (state != ST_IDLE);
    assign accept = e_fall && sel_s && !busy && !(rw_s && !rs_s);
    assign ram_we = (state == ST_EXEC) && cmd.rs && !cmd.rw;

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept) state_nx = ST_EXEC;
            ST_EXEC: state_nx = (BUSY_CYC > 1) ? ST_HOLD : ST_IDLE;
            ST_HOLD: if (hold_cnt == 2'(PAD)) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // datapath and architectural registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd        <= '0;
            hold_cnt   <= '0;
            col        <= '0;
            page       <= '0;
            out_reg    <= '0;
            disp_on    <= 1'b0;
            start_line <= '0;
        end else begin
            if (accept) begin
                cmd <= '{rs: rs_s, rw: rw_s, db: db_s};
            end
            hold_cnt <= (state == ST_HOLD) ? hold_cnt + 2'd1 : 2'd0;
            if (state == ST_EXEC) begin
                if (cmd.rs) begin
                    col <= col + 1'b1;
                    if (cmd.rw) begin
                        out_reg <= ram_rdata;
                    end
                end else if (!cmd.rw) begin
                    if (op_is_display(cmd.db)) begin
                        disp_on <= cmd.db[0];
                    end else if (op_is_column(cmd.db)) begin
                        col <= cmd.db[COL_W-1:0];
                    end else if (op_is_page(cmd.db)) begin
                        page <= cmd.db[PAGE_W-1:0];
                    end else if (op_is_start(cmd.db)) begin
                        start_line <= cmd.db[5:0];
                    end
                end
            end
        end
    end

    // host-side read mux
    always_comb begin
        db_oe  = e_hi && sel_s && rw_s;
        db_out = out_reg;
        if (!rs_s) begin
            db_out = 8'h00;
            db_out[STAT_BUSY_BIT]  = busy;
            db_out[STAT_OFF_BIT]   = ~disp_on;
            db_out[STAT_RESET_BIT] = ~rst_n;
        end
    end

    // busy run length for the R8 bound
    logic [1:0] busy_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= '0;
        end else if (!busy) begin
            busy_run <= '0;
        end else if (busy_run != 2'd3) begin
            busy_run <= busy_run + 2'd1;
        end
    end

    a_r8_busy_bounded: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (busy_run < 2'd3));

    a_r7_col_step: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EXEC && cmd.rs) |=> (col == COL_W'($past(col) + 1'b1)));

    a_r7_page_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state != ST_EXEC) |=> $stable(page));

    a_r4_status_zero_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (db_oe && !rs_s) |-> (db_out[6] == 1'b0 && db_out[3:0] == 4'h0));

    a_r1_idle_when_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && !sel_s) |=> (state == ST_IDLE));

endmodule

// File: tb/test_glcd_host_if.sv
module test_glcd_host_if;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_e = 1'b0, bus_rw = 1'b0, bus_rs = 1'b0;
    logic       cs1_n = 1'b1, cs2_n = 1'b1, cs3 = 1'b0;
    logic [7:0] db_in = 8'h00;
    logic [7:0] db_out;
    logic       db_oe, disp_on;
    logic [5:0] start_line;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    glcd_host_if i_glcd_host_if (
        .clk(clk), .rst_n(rst_n), .bus_e(bus_e), .bus_rw(bus_rw), .bus_rs(bus_rs),
        .cs1_n(cs1_n), .cs2_n(cs2_n), .cs3(cs3), .db_in(db_in),
        .db_out(db_out), .db_oe(db_oe), .disp_on(disp_on), .start_line(start_line)
    );

    task automatic check(input string tag, input logic [8:0] act, input logic [8:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic finish_run;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    // one full bus cycle; q = {db_oe, db_out} sampled at the end of E high
    task automatic access(input logic rs, input logic rw, input logic [7:0] d,
                          input logic sel, output logic [8:0] q);
        @(negedge clk);
        cs1_n = ~sel; cs2_n = 1'b0; cs3 = 1'b1;
        bus_rs = rs; bus_rw = rw; db_in = d; bus_e = 1'b1;
        repeat (4) @(negedge clk);
        q = {db_oe, db_out};
        bus_e = 1'b0;
        repeat (8) @(negedge clk);
        cs1_n = 1'b1;
    endtask

    task automatic instr(input logic [7:0] d);
        logic [8:0] q;
        access(1'b0, 1'b0, d, 1'b1, q);
    endtask

    task automatic wr(input logic [7:0] d);
        logic [8:0] q;
        access(1'b1, 1'b0, d, 1'b1, q);
    endtask

    task automatic rd(output logic [7:0] d);
        logic [8:0] q;
        access(1'b1, 1'b1, 8'h00, 1'b1, q);
        d = q[7:0];
    endtask

    task automatic status(output logic [8:0] q);
        access(1'b0, 1'b1, 8'h00, 1'b1, q);
    endtask

    task automatic t_reset;
        logic [8:0] q;
        status(q);
        check("R9 status during reset", q, 9'h130);
        check("R9 disp off in reset", {8'h0, disp_on}, 9'h0);
        instr(8'h3F);
        check("R9 instruction ignored in reset", {8'h0, disp_on}, 9'h0);
        rst_n = 1'b1;
        status(q);
        check("R4 status after release", q, 9'h120);
    endtask

    task automatic t_display;
        logic [8:0] q;
        instr(8'h3F);
        check("R3 display on", {8'h0, disp_on}, 9'h1);
        status(q);
        check("R4 status display on", q, 9'h100);
        instr(8'hC0 | 8'd37);
        check("R3 start line 37", {3'h0, start_line}, 9'd37);
    endtask

    task automatic t_select;
        logic [8:0] q;
        access(1'b0, 1'b0, 8'hC5, 1'b0, q);
        check("R1 deselected write ignored", {3'h0, start_line}, 9'd37);
        access(1'b0, 1'b1, 8'h00, 1'b0, q);
        check("R1 R2 no drive when deselected", {8'h0, q[8]}, 9'h0);
    endtask

    task automatic t_data;
        logic [7:0] d;
        instr(8'hB8 | 8'd3);
        instr(8'h40 | 8'd5);
        wr(8'hA1); wr(8'hB2); wr(8'hC3);
        instr(8'h40 | 8'd5);
        rd(d);
        rd(d);
        check("R5 read col5", {1'b0, d}, 9'h0A1);
        rd(d);
        check("R5 R7 read col6", {1'b0, d}, 9'h0B2);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        instr(8'h40 | 8'd63);
        wr(8'h55); wr(8'h66);
        instr(8'h40 | 8'd63);
        rd(d);
        check("R6 dummy returns stale C3", {1'b0, d}, 9'h0C3);
        rd(d);
        check("R7 col63", {1'b0, d}, 9'h055);
        rd(d);
        check("R7 wrap to col0 same page", {1'b0, d}, 9'h066);
    endtask

    task automatic t_pages;
        logic [7:0] d;
        instr(8'hB8 | 8'd4);
        instr(8'h40 | 8'd5);
        wr(8'h77);
        instr(8'hB8 | 8'd3);
        instr(8'h40 | 8'd5);
        rd(d); rd(d);
        check("R5 page3 untouched", {1'b0, d}, 9'h0A1);
        instr(8'hB8 | 8'd4);
        instr(8'h40 | 8'd5);
        rd(d); rd(d);
        check("R5 page4 col5", {1'b0, d}, 9'h077);
    endtask

    task automatic t_busy;
        logic [8:0] q;
        // write start line 10, then status read raised one cycle after the fall
        @(negedge clk);
        cs1_n = 1'b0; cs2_n = 1'b0; cs3 = 1'b1;
        bus_rs = 1'b0; bus_rw = 1'b0; db_in = 8'hC0 | 8'd10; bus_e = 1'b1;
        repeat (4) @(negedge clk);
        bus_e = 1'b0;
        @(negedge clk);
        bus_rw = 1'b1; bus_e = 1'b1;
        repeat (2) @(negedge clk);
        check("R8 busy seen in status", {7'h0, db_oe, db_out[7]}, 9'h3);
        repeat (4) @(negedge clk);
        check("R8 busy cleared", {7'h0, db_oe, db_out[7]}, 9'h2);
        bus_e = 1'b0;
        repeat (8) @(negedge clk);
        check("R3 start line 10", {3'h0, start_line}, 9'd10);
        // second strobe falls while the first is still busy
        bus_rw = 1'b0; db_in = 8'hC0 | 8'd11; bus_e = 1'b1;
        repeat (4) @(negedge clk);
        bus_e = 1'b0;
        @(negedge clk);
        db_in = 8'hC0 | 8'd20; bus_e = 1'b1;
        @(negedge clk);
        bus_e = 1'b0;
        repeat (10) @(negedge clk);
        cs1_n = 1'b1;
        check("R8 first accepted", {3'h0, start_line}, 9'd11);
    endtask

    task automatic t_midreset;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check("R9 reset clears start line", {3'h0, start_line}, 9'd0);
        check("R9 reset turns display off", {8'h0, disp_on}, 9'h0);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_display();
        t_select();
        t_data();
        t_wrap();
        t_pages();
        t_busy();
        t_midreset();
        repeat (4) @(negedge clk);
        finish_run();
    end

endmodule